// File: doc/BRIEF.md
# Eight-Byte Circulant Column Mixer

This block is the diffusion step of a wide byte-oriented permutation. It takes one column of eight bytes and returns that column multiplied by a fixed circulant 8×8 matrix over GF(2^8). A full permutation state holds several such columns. Either one copy of the block per column, or one copy reused across the columns, gives the complete diffusion layer.

The field products never use a general multiplier. Every input byte is doubled twice through a shared bank of doublers. Each output byte is then the XOR of the doublings that its coefficients select. The coefficients are 2, 2, 3, 4, 5, 3, 5 and 7, so no coefficient is larger than 7, and the identity, double and quadruple of each byte cover every product.

A parameter selects one of two output forms:
- a combinational output, or
- a single output register, which adds one cycle of latency and has a synchronous active-high reset.

Top module: `colmix8`

## Requirements
- R1: Field doubling shifts a byte left by one position. When the bit shifted out was 1, the result is XORed with 0x1B, which is reduction by x^8+x^4+x^3+x+1. For example, 2·0x80 = 0x1B and 4·0x80 = 0x36.
- R2: Byte j of a column sits at bits [8j+7:8j], for both `col_i` and `col_o`.
- R3: Output byte i equals the GF(2^8) XOR-sum over j of c[(j−i) mod 8] · in[j], where c0..c7 = 02,02,03,04,05,03,05,07.
- R4: A column of all zeros produces a column of all zeros.
- R5: A column of all 0xFF bytes produces 0x1A in every output byte.
- R6: The mapping is linear: mix(a XOR b) equals mix(a) XOR mix(b).
- R7: Moving every input byte up by one position (byte 7 wraps to byte 0) moves every output byte up by one position in the same way.
- R8: With the output register enabled (the default), `col_o` shows the mix of the `col_i` that was present at the previous rising edge of `clk`.
- R9: While `rst` is high at a rising edge, the registered `col_o` becomes zero, whatever `col_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| col_i | input | 64 | Input column, byte j at bits [8j+7:8j] |
| col_o | output | 64 | Mixed column, same byte layout |

## Verification
In the default registered form, every result is due at the first rising edge after the column is applied. Reset clears the output at that same edge. The bench drives each column on a falling edge and reads `col_o` on the next falling edge, which is half a period after the capturing rising edge. The bench compares each result against a reference model that uses a general shift-and-add field multiplier. It also compares against hand-computed impulse and all-0xFF columns. Linearity and rotation are checked by applying the related columns one after another, each with its own one-cycle wait.

// File: rtl/colmix_pkg.sv
package colmix_pkg;
  localparam int BYTE_W = 8;

  // One field doubling with the low byte of the reduction polynomial.
  function automatic logic [BYTE_W-1:0] gf_double(input logic [BYTE_W-1:0] a,
                                                   input logic [BYTE_W-1:0] poly_lo);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? poly_lo : '0);
  endfunction

  // Number of doubling levels needed to cover the largest coefficient.
  function automatic int coef_levels(input logic [255:0] coefs, input int n_bytes);
    int top;
    top = 1;
    for (int k = 0; k < n_bytes; k++)
      for (int b = 0; b < BYTE_W; b++)
        if (coefs[k*BYTE_W+b] && (b + 1) > top) top = b + 1;
    return top;
  endfunction
endpackage

// File: rtl/colmix_dbl_bank.sv
module colmix_dbl_bank
  import colmix_pkg::*;
#(
  parameter int              N_BYTES = 8,
  parameter int              N_LVL   = 3,
  parameter logic [BYTE_W-1:0] POLY  = 8'h1B
) (
  input  logic [N_BYTES*BYTE_W-1:0]       col,
  output logic [N_LVL*N_BYTES*BYTE_W-1:0] lvl
);
  localparam int COL_W = N_BYTES * BYTE_W;

  assign lvl[COL_W-1:0] = col;

  genvar p, j;
  generate
    for (p = 1; p < N_LVL; p++) begin : g_lvl
      for (j = 0; j < N_BYTES; j++) begin : g_byte
        logic [BYTE_W-1:0] src, dst;
        assign src = lvl[((p-1)*N_BYTES+j)*BYTE_W +: BYTE_W];
        assign dst = gf_double(src, POLY);
        assign lvl[(p*N_BYTES+j)*BYTE_W +: BYTE_W] = dst;

        // R1: the reduction constant has bit 0 set, so the low bit of a double is the bit shifted out
        always_comb begin
          a_r1_dbl_lsb: assert (dst[0] == src[BYTE_W-1]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/colmix_row.sv
module colmix_row
  import colmix_pkg::*;
#(
  parameter int                      N_BYTES = 8,
  parameter int                      N_LVL   = 3,
  parameter int                      ROW     = 0,
  parameter logic [N_BYTES*BYTE_W-1:0] COEF  = 64'h0705030504030202
) (
  input  logic [N_LVL*N_BYTES*BYTE_W-1:0] lvl,
  output logic [BYTE_W-1:0]               byte_o
);
  always_comb begin
    byte_o = '0;
    for (int j = 0; j < N_BYTES; j++) begin
      for (int p = 0; p < N_LVL; p++) begin
        if (COEF[((j - ROW + N_BYTES) % N_BYTES)*BYTE_W + p])
          byte_o = byte_o ^ lvl[(p*N_BYTES+j)*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/colmix8.sv
module colmix8
  import colmix_pkg::*;
#(
  parameter int                      N_BYTES = 8,
  parameter logic [BYTE_W-1:0]       POLY    = 8'h1B,
  parameter logic [N_BYTES*BYTE_W-1:0] COEF  = 64'h0705030504030202,
  parameter bit                      REG_OUT = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_BYTES*BYTE_W-1:0]   col_i,
  output logic [N_BYTES*BYTE_W-1:0]   col_o
);
  localparam int COL_W = N_BYTES * BYTE_W;
  localparam int N_LVL = coef_levels({{(256-COL_W){1'b0}}, COEF}, N_BYTES);

  logic [N_LVL*COL_W-1:0] lvl;
  logic [COL_W-1:0]       mix_w;

  colmix_dbl_bank #(.N_BYTES(N_BYTES), .N_LVL(N_LVL), .POLY(POLY)) u_dbl (
    .col (col_i),
    .lvl (lvl)
  );

  genvar i;
  generate
    for (i = 0; i < N_BYTES; i++) begin : g_row
      colmix_row #(.N_BYTES(N_BYTES), .N_LVL(N_LVL), .ROW(i), .COEF(COEF)) u_row (
        .lvl    (lvl),
        .byte_o (mix_w[i*BYTE_W +: BYTE_W])
      );
    end

    if (REG_OUT) begin : g_reg
      logic [COL_W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= mix_w;
      end
      assign col_o = out_q;

      // R8: one cycle of latency from the network to the port
      a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (col_o == $past(mix_w)));
      // R4: a zero column leaves a zero column one cycle later
      a_r4_zero: assert property (@(posedge clk) disable iff (rst)
        (col_i == '0) |=> (col_o == '0));
      // R8: a held column gives a held output
      a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(col_i)) |=> $stable(col_o));
      // R9: reset clears the output register
      a_r9_reset: assert property (@(posedge clk)
        rst |=> (col_o == '0));
    end else begin : g_comb
      assign col_o = mix_w;
      // R4: a zero column yields zero
      always_comb begin
        if (col_i == '0) a_r4_zero_comb: assert (col_o == '0);
      end
    end
  endgenerate
endmodule

// File: tb/colmix8_tb.sv
module colmix8_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] col_i = '0;
  logic [63:0] col_o;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  colmix8 u_dut (.clk(clk), .rst(rst), .col_i(col_i), .col_o(col_o));

  localparam logic [63:0] VEC [0:9] = '{
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF,
    64'hFEDC_BA98_7654_3210, 64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101,
    64'hDEAD_BEEF_CAFE_F00D, 64'h00FF_00FF_00FF_00FF, 64'h5555_AAAA_3333_CCCC,
    64'h1B1B_1B1B_0000_0000
  };

  // Reference: general shift-and-add multiply mod 0x11B
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = '0; x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_mix(input logic [63:0] v);
    logic [7:0] c [0:7];
    logic [63:0] o;
    c = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};
    o = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        o[i*8 +: 8] ^= ref_mul(c[(j - i + 8) % 8], v[j*8 +: 8]);
    return o;
  endfunction

  function automatic logic [63:0] rot_up(input logic [63:0] v);
    return {v[55:0], v[63:56]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge, read one full cycle later
  task automatic apply(input logic [63:0] v, output logic [63:0] r);
    @(negedge clk) col_i = v;
    @(negedge clk) r = col_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [63:0] r, ra, rb, rx, a, b;
    // R9: reset state with a nonzero column present
    col_i = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R9 reset clears output", col_o, 64'h0);
    @(negedge clk) rst = 1'b0;

    // R3: table walk against reference model
    for (int t = 0; t < 10; t++) begin
      apply(VEC[t], r);
      check("R3 table vector", r, ref_mix(VEC[t]));
    end
    // R3/R2: hand-computed impulse at byte 0
    apply(64'h0000_0000_0000_0001, r);
    check("R3 R2 impulse 01", r, 64'h0203_0405_0305_0702);
    // R1: impulse 0x80 exercises reduction
    apply(64'h0000_0000_0000_0080, r);
    check("R1 impulse 80", r, 64'h1B9B_36B6_9BB6_AD1B);
    // R4
    apply(64'h0, r);
    check("R4 all zero", r, 64'h0);
    // R5
    apply(64'hFFFF_FFFF_FFFF_FFFF, r);
    check("R5 all ff", r, 64'h1A1A_1A1A_1A1A_1A1A);
    // random columns, R6 and R7
    for (int t = 0; t < 40; t++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      apply(a, ra);
      check("R3 random", ra, ref_mix(a));
      apply(b, rb);
      apply(a ^ b, rx);
      check("R6 linearity", rx, ra ^ rb);
      apply(rot_up(a), r);
      check("R7 rotation", r, rot_up(ra));
    end
    // R8: output follows each new column after exactly one edge
    @(negedge clk) col_i = 64'h0000_0000_0000_0001;
    @(posedge clk); #1;
    col_i = 64'h0;
    @(negedge clk);
    check("R8 one-cycle latency", col_o, 64'h0203_0405_0305_0702);
    @(negedge clk);
    check("R8 next column", col_o, 64'h0);
    // R9: reset mid-run overrides a nonzero column
    @(negedge clk) begin col_i = 64'h0123_4567_89AB_CDEF; rst = 1'b1; end
    @(negedge clk);
    check("R9 reset mid-run", col_o, 64'h0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R8 after reset release", col_o, ref_mix(64'h0123_4567_89AB_CDEF));
    finish_run();
  end
endmodule